// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Controller

This block watches one asynchronous external interrupt line and raises a single request towards a parent interrupt controller. The line is first brought into the clock domain through a two-stage synchronizer. It is then qualified by a programmable trigger mode: active-low level, active-high level, falling edge or rising edge. A qualifying event latches a sticky pending flag, and the outgoing request is that flag gated by an enable bit.

Software reaches the block through a plain synchronous register port with separate read and write strobes. Three registers are mapped: a control word whose two lowest bits select the trigger mode, a pending word, and an enable word. The pending and enable words use only bit 0. A parameter selects one of three placements of these registers in the address space, so the same block fits several address maps.

Top module: `nmi_line_ctrl`

## Requirements
- R1: While reset is held, and directly after it, the control word, the enable bit and the pending flag read 0 and `irq_out` is low.
- R2: Control bits [1:0] select the trigger: 0 = line low (level), 1 = high-to-low transition, 2 = line high (level), 3 = low-to-high transition.
- R3: Writing a word with bit 0 set to the pending register clears the flag. A write with bit 0 at 0 leaves it unchanged.
- R4: In an edge mode, the flag is set on the third rising clock edge after the line changes in the selected direction. A change in the other direction sets nothing. The flag stays set until software clears it.
- R5: In a level mode, the flag is set on every clock in which the synchronized line is at the active level. A clear issued while that level persists is overridden, so the flag reads 1.
- R6: `irq_out` equals the pending flag ANDed with enable bit 0. With enable at 0 the output stays low, but the flag is still recorded and shows on the output as soon as the enable bit is set.
- R7: MAP selects the offsets. MAP_WIDE: control 0x00, pending 0x04, enable 0x34. MAP_PACKED (default): control 0x00, pending 0x04, enable 0x08. MAP_SWAPPED: control 0x00, enable 0x04, pending 0x08.
- R8: All DATA_W control bits are plain read/write storage. Rewriting bits [1:0] with the other bits unchanged preserves those other bits.
- R9: Reads of offsets outside the selected map return 0. Only bit 0 of the enable word is stored, and it reads back in bit 0 with the other bits 0. The same holds for the pending word.
- R10: Changing the trigger mode while the line is steady never sets the flag by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| nmi_in | input | 1 | Asynchronous external interrupt line |
| irq_out | output | 1 | Request to the parent controller |

## Verification
The assertions assume that `nmi_in` is low when reset is released. If it were high, the reset value of the synchronizer would show a false low-to-high transition. They also assume that a write strobe is never raised together with a read strobe that the same cycle depends on. The bench holds `nmi_in` low through reset and changes it only at falling clock edges. It issues each bus access as a single-cycle strobe between falling edges, and it waits at least three clocks after every line change before it samples pending state. The edge-timing checks are the exception: they sample deliberately at the second and third edge after the change.

// File: rtl/nmi_ctrl_pkg.sv
package nmi_ctrl_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LOW   = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HIGH  = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    MAP_WIDE    = 2'd0,
    MAP_PACKED  = 2'd1,
    MAP_SWAPPED = 2'd2
  } reg_map_e;

  // Offset helpers, one per register
  function automatic int ctrl_offset(reg_map_e m);
    return (m == MAP_WIDE) ? 0 : 0;
  endfunction

  function automatic int pend_offset(reg_map_e m);
    return (m == MAP_SWAPPED) ? 8 : 4;
  endfunction

  function automatic int enable_offset(reg_map_e m);
    case (m)
      MAP_WIDE:    return 52;
      MAP_PACKED:  return 8;
      default:     return 4;
    endcase
  endfunction

  // Bit 0 of the code marks an edge mode, bit 1 gives the active/target level
  function automatic logic mode_is_edge(trig_mode_e m);
    return m[0];
  endfunction

  function automatic logic mode_level(trig_mode_e m);
    return m[1];
  endfunction

  function automatic logic trigger_hit(trig_mode_e m, logic cur, logic prev);
    if (mode_is_edge(m))
      return (cur == mode_level(m)) && (prev != mode_level(m));
    return cur == mode_level(m);
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
module nmi_detect
  import nmi_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  trig_mode_e mode,
  input  logic       clr_req,
  output logic       pend_q,
  output logic       set_evt
);
  logic prev_q;

  // prev_q tracks the line independently of the mode, so a mode change cannot fake an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_in;
  end

  assign set_evt = trigger_hit(mode, sync_in, prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (clr_req) pend_q <= 1'b0;
  end

  // R3
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !set_evt |=> !pend_q);

  // R4
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr_req |=> pend_q);

  // R5
  lvl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[0] && (sync_in == mode[1]) |=> pend_q);

  // R10
  no_fake_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[0] && (sync_in == prev_q) && !clr_req |=> pend_q == $past(pend_q));
endmodule

// File: rtl/nmi_ctrl_regs.sv
module nmi_ctrl_regs
  import nmi_ctrl_pkg::*;
#(
  parameter reg_map_e MAP    = MAP_PACKED,
  parameter int       ADDR_W = 8,
  parameter int       DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pend_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              en_q,
  output logic              clr_req
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(ctrl_offset(MAP));
  localparam logic [ADDR_W-1:0] PEND_A = ADDR_W'(pend_offset(MAP));
  localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(enable_offset(MAP));

  logic hit_ctrl, hit_pend, hit_en;
  assign hit_ctrl = (bus_addr == CTRL_A);
  assign hit_pend = (bus_addr == PEND_A);
  assign hit_en   = (bus_addr == EN_A);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (bus_wr) begin
      if (hit_ctrl) ctrl_q <= bus_wdata;
      if (hit_en)   en_q   <= bus_wdata[0];
    end
  end

  assign clr_req = bus_wr && hit_pend && bus_wdata[0];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)      bus_rdata = ctrl_q;
      else if (hit_pend) bus_rdata = DATA_W'(pend_q);
      else if (hit_en)   bus_rdata = DATA_W'(en_q);
    end
  end

  // R9
  en_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && hit_en |=> en_q == $past(bus_wdata[0]));

  // R8
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/nmi_line_ctrl.sv
module nmi_line_ctrl
  import nmi_ctrl_pkg::*;
#(
  parameter reg_map_e MAP         = MAP_PACKED,
  parameter int       ADDR_W      = 8,
  parameter int       DATA_W      = 32,
  parameter int       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              nmi_in,
  output logic              irq_out
);
  logic [DATA_W-1:0] ctrl_q;
  logic              en_q, clr_req, pend_q, set_evt, line_sync;
  trig_mode_e        mode;

  assign mode = trig_mode_e'(ctrl_q[1:0]);

  nmi_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(nmi_in), .dout(line_sync)
  );

  nmi_detect det_i (
    .clk(clk), .rst_n(rst_n), .sync_in(line_sync), .mode(mode),
    .clr_req(clr_req), .pend_q(pend_q), .set_evt(set_evt)
  );

  nmi_ctrl_regs #(.MAP(MAP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .ctrl_q(ctrl_q), .en_q(en_q), .clr_req(clr_req)
  );

  assign irq_out = pend_q && en_q;

  // R6
  mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && (bus_addr == ADDR_W'(enable_offset(MAP))) && !bus_wdata[0] |=> !irq_out);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_out);
endmodule

// File: tb/nmi_line_ctrl_tb_top.sv
module nmi_line_ctrl_tb_top;
  import nmi_ctrl_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, nmi_in = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] rdata_i, rdata_a, rdata_c, rd_i, rd_a, rd_c;
  logic irq_i, irq_a, irq_c;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_line_ctrl #(.MAP(MAP_PACKED)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_i), .nmi_in(nmi_in), .irq_out(irq_i));
  nmi_line_ctrl #(.MAP(MAP_WIDE)) dut_a (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .nmi_in(nmi_in), .irq_out(irq_a));
  nmi_line_ctrl #(.MAP(MAP_SWAPPED)) dut_c (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_c), .nmi_in(nmi_in), .irq_out(irq_c));

  // Offsets of the main instance (packed map)
  localparam logic [AW-1:0] CTL = 8'h00, PND = 8'h04, ENB = 8'h08;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    rd_i = rdata_i; rd_a = rdata_a; rd_c = rdata_c;
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    idle(3);
    bus_read(CTL);  check("R1 ctrl in reset", rd_i, 0);
    bus_read(ENB);  check("R1 enable in reset", rd_i, 0);
    bus_read(PND);  check("R1 pending in reset", rd_i, 0);
    check("R1 irq_out in reset", {31'b0, irq_i}, 0);
    @(negedge clk); rst_n = 1'b1;
    bus_read(CTL);  check("R1 ctrl after reset", rd_i, 0);
    bus_read(ENB);  check("R1 enable after reset", rd_i, 0);
  endtask

  task automatic t_layout;
    // Mode 0 (line low) with nmi_in low: every instance latches pending
    idle(4);
    bus_read(8'h04); check("R7 wide pending@04", rd_a, 1);
                     check("R7 packed pending@04", rd_i, 1);
                     check("R7 swapped enable@04", rd_c, 0);
    bus_read(8'h08); check("R7 swapped pending@08", rd_c, 1);
    bus_write(8'h34, 32'h1);
    bus_read(8'h34); check("R7 wide enable@34", rd_a, 1);
                     check("R9 packed unmapped@34", rd_i, 0);
    check("R6 wide irq after enable", {31'b0, irq_a}, 1);
    bus_write(8'h08, 32'h1);
    bus_read(8'h08); check("R7 packed enable@08", rd_i, 1);
    bus_write(8'h04, 32'h1);
    bus_read(8'h04); check("R7 swapped enable@04 set", rd_c, 1);
    bus_read(8'h0C); check("R9 unmapped 0C", rd_i, 0);
    bus_write(8'h34, 0); bus_write(8'h08, 0); bus_write(8'h04, 0);
  endtask

  task automatic t_rise_timing;
    bus_write(CTL, 32'h3);
    bus_write(PND, 32'h1);
    bus_write(ENB, 32'h1);
    check("R4 no irq before edge", {31'b0, irq_i}, 0);
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 not yet after two edges", {31'b0, irq_i}, 0);
    @(negedge clk);
    check("R4 set on third edge", {31'b0, irq_i}, 1);
    nmi_in = 1'b0; idle(5);
    check("R4 sticky after line drop", {31'b0, irq_i}, 1);
    bus_write(PND, 32'h1); idle(4);
    bus_read(PND); check("R4 falling ignored in rising mode", rd_i, 0);
  endtask

  task automatic t_fall_and_w0;
    bus_write(CTL, 32'h1);
    nmi_in = 1'b1; idle(5);
    bus_read(PND); check("R2 falling mode ignores rise", rd_i, 0);
    nmi_in = 1'b0; idle(5);
    bus_read(PND); check("R2 falling mode sets", rd_i, 1);
    bus_write(PND, 32'hFFFF_FFFE);
    bus_read(PND); check("R3 write 0 keeps pending", rd_i, 1);
    bus_write(PND, 32'h1);
    bus_read(PND); check("R3 write 1 clears", rd_i, 0);
  endtask

  task automatic t_level_override;
    bus_write(CTL, 32'h2);
    nmi_in = 1'b1; idle(4);
    bus_write(PND, 32'h1);
    bus_read(PND); check("R5 clear overridden while high", rd_i, 1);
    nmi_in = 1'b0; idle(4);
    bus_write(PND, 32'h1);
    bus_read(PND); check("R5 clear works when inactive", rd_i, 0);
    bus_write(CTL, 32'h0); idle(4);
    bus_read(PND); check("R2 mode 0 sets on low line", rd_i, 1);
  endtask

  task automatic t_mask;
    bus_write(ENB, 32'hFFFF_FFFE);
    bus_read(ENB); check("R9 enable only bit0 stored", rd_i, 0);
    bus_write(CTL, 32'h2);
    bus_write(PND, 32'h1);
    nmi_in = 1'b1; idle(4);
    check("R6 masked output low", {31'b0, irq_i}, 0);
    bus_read(PND); check("R6 masked pending recorded", rd_i, 1);
    bus_write(ENB, 32'hFFFF_FFFF);
    check("R6 irq after unmask", {31'b0, irq_i}, 1);
    bus_read(ENB); check("R9 enable reads bit0 only", rd_i, 1);
  endtask

  task automatic t_mode_swap;
    // line held high; switch level-high -> rising -> falling
    bus_write(CTL, 32'h3);
    bus_write(PND, 32'h1); idle(4);
    bus_read(PND); check("R10 no set on switch to rising", rd_i, 0);
    bus_write(CTL, 32'h1); idle(4);
    bus_read(PND); check("R10 no set on switch to falling", rd_i, 0);
    nmi_in = 1'b0; idle(4);
    bus_read(PND); check("R10 real falling edge still sets", rd_i, 1);
  endtask

  task automatic t_ctrl_store;
    bus_write(CTL, 32'hABCD_1202);
    bus_read(CTL); check("R8 ctrl full word", rd_i, 32'hABCD_1202);
    bus_write(CTL, (rd_i & ~32'h3) | 32'h3);
    bus_read(CTL); check("R8 upper bits preserved", rd_i, 32'hABCD_1203);
  endtask

  initial begin
    t_reset();
    t_layout();
    t_rise_timing();
    t_fall_and_w0();
    t_level_override();
    t_mask();
    t_mode_swap();
    t_ctrl_store();
    idle(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule